// File: doc/BRIEF.md
# Speculative register busy scoreboard

This block keeps one status bit per physical register of a register file and says whether that register is still waiting for its value. Rename marks destination registers busy through a group of allocate ports. Speculative wake-up ports and write-back ports clear them back to ready. An early-stage cancel port, and on the integer file a load-cancel port, mark a speculatively woken register busy again.

Dispatch reads the table through many combinational read ports, one for each source operand of each instruction in the issue group, to learn which sources are ready. The reads see the registered table only, so an update made in a cycle shows on the read ports in the next cycle. Every port count, the register count, the load-cancel option and the hardwired-zero option are parameters, and elaboration checks reject settings that cannot work.

Top module: `reg_busy_scoreboard`

## Requirements
- R1: After reset every entry is ready, so every read port returns rd_ready = 1 (1 means ready, 0 means busy).
- R2: A register presented on a valid allocate port reads busy (rd_ready = 0) from the next cycle on.
- R3: A register presented on a valid wake-up port, with no set request for it in the same cycle, reads ready from the next cycle on.
- R4: A register presented on a valid write-back port, with no set request for it in the same cycle, reads ready from the next cycle on.
- R5: A register presented on a valid early-cancel port reads busy from the next cycle on, even when a wake-up or write-back names the same register in that cycle.
- R6: With LDCANCEL_EN = 1 a valid load-cancel port marks its register busy with the same priority as the early cancel; with LDCANCEL_EN = 0 the load-cancel ports have no effect on any entry.
- R7: When an allocate and a wake-up or write-back name the same register in one cycle, the register reads busy in the next cycle.
- R8: Read ports are combinational on the registered table: an update requested in a cycle is not visible on the read ports in that same cycle.
- R9: The block has SRC_PER_INST × ISSUE_WIDTH read ports, each returning the state of the register its address selects.
- R10: With ZERO_HARDWIRED = 1, physical register 0 always reads ready and ignores allocate and cancel requests; with ZERO_HARDWIRED = 0 it behaves like any other register.
- R11: An entry that no port names in a cycle keeps its state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, clears the whole table to ready |
| alloc_vld | input | ALLOC_PORTS | Allocate request valid, one bit per port |
| alloc_preg | input | ALLOC_PORTS × IDX_W | Destination register of each allocate port |
| wake_vld | input | WAKE_PORTS | Speculative wake-up valid |
| wake_preg | input | WAKE_PORTS × IDX_W | Register woken by each wake-up port |
| wb_vld | input | WB_PORTS | Write-back valid |
| wb_preg | input | WB_PORTS × IDX_W | Register written back by each port |
| cancel_vld | input | CANCEL_PORTS | Early-stage cancel valid |
| cancel_preg | input | CANCEL_PORTS × IDX_W | Register re-marked busy by each cancel port |
| ldc_vld | input | LDC_PORTS | Load-cancel valid (used only when LDCANCEL_EN = 1) |
| ldc_preg | input | LDC_PORTS × IDX_W | Register re-marked busy by each load-cancel port |
| rd_preg | input | RD_PORTS × IDX_W | Source register address of each read port |
| rd_ready | output | RD_PORTS | 1 when the addressed register is ready |

## Verification
The bench builds two copies with 16 registers, two ports of each update kind, one cancel port and one load-cancel port, and four read ports (two sources, issue width two). One copy has the load-cancel option and the hardwired zero register on, the other has both off, so the same stimulus shows load-cancel taking effect and being ignored, and register 0 being fixed or free. The small register count makes random updates collide on the same entry often, which brings every priority pairing (cancel against wake-up, allocate against write-back) within reach many times in a few hundred cycles.

// File: rtl/sb_pkg.sv
package sb_pkg;

   // Set requests outrank clear requests; otherwise the entry holds.
   function automatic logic next_busy(input logic cur, input logic set_req, input logic clr_req);
      logic nb;
      if (set_req)      nb = 1'b1;
      else if (clr_req) nb = 1'b0;
      else              nb = cur;
      return nb;
   endfunction

endpackage

// File: rtl/sb_hit_decode.sv
module sb_hit_decode #(
   parameter int NUM_PREGS = 64,
   parameter int PORTS     = 4,
   parameter int IDX_W     = $clog2(NUM_PREGS)
) (
   input  logic [PORTS-1:0]            vld,
   input  logic [PORTS-1:0][IDX_W-1:0] idx,
   output logic [NUM_PREGS-1:0]        hit
);

   always_comb begin
      hit = '0;
      for (int p = 0; p < PORTS; p++) begin
         if (vld[p] && (int'(idx[p]) < NUM_PREGS)) hit[idx[p]] = 1'b1;
      end
   end

endmodule

// File: rtl/sb_read_ports.sv
module sb_read_ports #(
   parameter int NUM_PREGS = 64,
   parameter int RD_PORTS  = 12,
   parameter int IDX_W     = $clog2(NUM_PREGS)
) (
   input  logic [NUM_PREGS-1:0]           busy,
   input  logic [RD_PORTS-1:0][IDX_W-1:0] addr,
   output logic [RD_PORTS-1:0]            ready
);

   genvar k;
   generate
      for (k = 0; k < RD_PORTS; k++) begin : g_rd
         // Out-of-range addresses read as ready.
         assign ready[k] = (int'(addr[k]) < NUM_PREGS) ? ~busy[addr[k]] : 1'b1;
      end
   endgenerate

endmodule

// File: rtl/reg_busy_scoreboard.sv
module reg_busy_scoreboard #(
   parameter int NUM_PREGS      = 64,
   parameter int ALLOC_PORTS    = 6,
   parameter int WAKE_PORTS     = 4,
   parameter int WB_PORTS       = 4,
   parameter int CANCEL_PORTS   = 2,
   parameter int LDC_PORTS      = 2,
   parameter bit LDCANCEL_EN    = 1'b1,
   parameter bit ZERO_HARDWIRED = 1'b1,
   parameter int SRC_PER_INST   = 2,
   parameter int ISSUE_WIDTH    = 6,
   localparam int IDX_W         = $clog2(NUM_PREGS),
   localparam int RD_PORTS      = SRC_PER_INST * ISSUE_WIDTH
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [ALLOC_PORTS-1:0]            alloc_vld,
   input  logic [ALLOC_PORTS-1:0][IDX_W-1:0] alloc_preg,
   input  logic [WAKE_PORTS-1:0]             wake_vld,
   input  logic [WAKE_PORTS-1:0][IDX_W-1:0]  wake_preg,
   input  logic [WB_PORTS-1:0]               wb_vld,
   input  logic [WB_PORTS-1:0][IDX_W-1:0]    wb_preg,
   input  logic [CANCEL_PORTS-1:0]           cancel_vld,
   input  logic [CANCEL_PORTS-1:0][IDX_W-1:0] cancel_preg,
   input  logic [LDC_PORTS-1:0]              ldc_vld,
   input  logic [LDC_PORTS-1:0][IDX_W-1:0]   ldc_preg,
   input  logic [RD_PORTS-1:0][IDX_W-1:0]    rd_preg,
   output logic [RD_PORTS-1:0]               rd_ready
);

   // Elaboration-time parameter checks
   generate
      if (NUM_PREGS < 2) begin : g_bad_pregs
         $error("NUM_PREGS must be at least 2");
      end
      if (ALLOC_PORTS < 1 || WAKE_PORTS < 1 || WB_PORTS < 1 ||
          CANCEL_PORTS < 1 || LDC_PORTS < 1) begin : g_bad_ports
         $error("every update port group needs at least one port");
      end
      if (RD_PORTS < 1) begin : g_bad_rd
         $error("SRC_PER_INST * ISSUE_WIDTH must be at least 1");
      end
   endgenerate

   logic [NUM_PREGS-1:0] busy_q, busy_d;
   logic [NUM_PREGS-1:0] alloc_hit, wake_hit, wb_hit, cancel_hit, ldc_hit, ldc_eff;
   logic [NUM_PREGS-1:0] set_req, clr_req;

   sb_hit_decode #(.NUM_PREGS(NUM_PREGS), .PORTS(ALLOC_PORTS), .IDX_W(IDX_W)) u_dec_alloc (
      .vld(alloc_vld), .idx(alloc_preg), .hit(alloc_hit));
   sb_hit_decode #(.NUM_PREGS(NUM_PREGS), .PORTS(WAKE_PORTS), .IDX_W(IDX_W)) u_dec_wake (
      .vld(wake_vld), .idx(wake_preg), .hit(wake_hit));
   sb_hit_decode #(.NUM_PREGS(NUM_PREGS), .PORTS(WB_PORTS), .IDX_W(IDX_W)) u_dec_wb (
      .vld(wb_vld), .idx(wb_preg), .hit(wb_hit));
   sb_hit_decode #(.NUM_PREGS(NUM_PREGS), .PORTS(CANCEL_PORTS), .IDX_W(IDX_W)) u_dec_cancel (
      .vld(cancel_vld), .idx(cancel_preg), .hit(cancel_hit));
   sb_hit_decode #(.NUM_PREGS(NUM_PREGS), .PORTS(LDC_PORTS), .IDX_W(IDX_W)) u_dec_ldc (
      .vld(ldc_vld), .idx(ldc_preg), .hit(ldc_hit));

   generate
      if (LDCANCEL_EN) begin : g_ldc_on
         assign ldc_eff = ldc_hit;
      end else begin : g_ldc_off
         assign ldc_eff = ldc_hit & '0;
      end
   endgenerate

   // Allocate, early cancel and load cancel all set; wake-up and write-back clear.
   assign set_req = alloc_hit | cancel_hit | ldc_eff;
   assign clr_req = wake_hit | wb_hit;

   genvar e;
   generate
      for (e = 0; e < NUM_PREGS; e++) begin : g_entry
         if (ZERO_HARDWIRED && e == 0) begin : g_zero
            assign busy_d[e] = 1'b0;
         end else begin : g_norm
            assign busy_d[e] = sb_pkg::next_busy(busy_q[e], set_req[e], clr_req[e]);

            // R5
            set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
               set_req[e] |=> busy_q[e]);
            // R3
            clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
               (clr_req[e] && !set_req[e]) |=> !busy_q[e]);
         end

         // R11
         hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!set_req[e] && !clr_req[e]) |=> (busy_q[e] == $past(busy_q[e])));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) busy_q <= '0;
      else        busy_q <= busy_d;
   end

   sb_read_ports #(.NUM_PREGS(NUM_PREGS), .RD_PORTS(RD_PORTS), .IDX_W(IDX_W)) u_rd (
      .busy(busy_q), .addr(rd_preg), .ready(rd_ready));

   genvar p, k;
   generate
      for (p = 0; p < ALLOC_PORTS; p++) begin : g_alloc_chk
         // R2
         alloc_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (alloc_vld[p] && !(ZERO_HARDWIRED && alloc_preg[p] == '0))
            |=> busy_q[$past(alloc_preg[p])]);
      end
      if (ZERO_HARDWIRED) begin : g_zero_chk
         for (k = 0; k < RD_PORTS; k++) begin : g_rdz
            // R10
            zero_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
               (rd_preg[k] == '0) |-> rd_ready[k]);
         end
      end
   endgenerate

endmodule

// File: tb/reg_busy_scoreboard_bench.sv
`timescale 1ns/1ps
module reg_busy_scoreboard_bench;

   localparam int NP  = 16;
   localparam int IW  = 4;
   localparam int NA  = 2;
   localparam int NWK = 2;
   localparam int NWB = 2;
   localparam int NC  = 1;
   localparam int NL  = 1;
   localparam int NR  = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic [NA-1:0]           a_v;
   logic [NA-1:0][IW-1:0]   a_p;
   logic [NWK-1:0]          w_v;
   logic [NWK-1:0][IW-1:0]  w_p;
   logic [NWB-1:0]          b_v;
   logic [NWB-1:0][IW-1:0]  b_p;
   logic [NC-1:0]           c_v;
   logic [NC-1:0][IW-1:0]   c_p;
   logic [NL-1:0]           l_v;
   logic [NL-1:0][IW-1:0]   l_p;
   logic [NR-1:0][IW-1:0]   r_p;
   logic [NR-1:0]           rdy_int, rdy_fp;

   reg_busy_scoreboard #(.NUM_PREGS(NP), .ALLOC_PORTS(NA), .WAKE_PORTS(NWK), .WB_PORTS(NWB),
      .CANCEL_PORTS(NC), .LDC_PORTS(NL), .LDCANCEL_EN(1'b1), .ZERO_HARDWIRED(1'b1),
      .SRC_PER_INST(2), .ISSUE_WIDTH(2)) u_reg_busy_scoreboard (
      .clk(clk), .rst_n(rst_n), .alloc_vld(a_v), .alloc_preg(a_p), .wake_vld(w_v), .wake_preg(w_p),
      .wb_vld(b_v), .wb_preg(b_p), .cancel_vld(c_v), .cancel_preg(c_p), .ldc_vld(l_v), .ldc_preg(l_p),
      .rd_preg(r_p), .rd_ready(rdy_int));

   reg_busy_scoreboard #(.NUM_PREGS(NP), .ALLOC_PORTS(NA), .WAKE_PORTS(NWK), .WB_PORTS(NWB),
      .CANCEL_PORTS(NC), .LDC_PORTS(NL), .LDCANCEL_EN(1'b0), .ZERO_HARDWIRED(1'b0),
      .SRC_PER_INST(2), .ISSUE_WIDTH(2)) u_reg_busy_scoreboard_fp (
      .clk(clk), .rst_n(rst_n), .alloc_vld(a_v), .alloc_preg(a_p), .wake_vld(w_v), .wake_preg(w_p),
      .wb_vld(b_v), .wb_preg(b_p), .cancel_vld(c_v), .cancel_preg(c_p), .ldc_vld(l_v), .ldc_preg(l_p),
      .rd_preg(r_p), .rd_ready(rdy_fp));

   int checks = 0;
   int errors = 0;
   bit ref_int [NP];
   bit ref_fp  [NP];

   task automatic clear_inputs();
      a_v = '0; a_p = '0; w_v = '0; w_p = '0; b_v = '0; b_p = '0;
      c_v = '0; c_p = '0; l_v = '0; l_p = '0;
   endtask

   task automatic check(string tag, string inst, int port, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s port %0d reg %0d: actual %0b expected %0b", tag, inst, port, r_p[port], act, exp);
      end
   endtask

   // Behavioural next state: any set request wins, then any clear, else hold.
   task automatic model_update();
      bit s_i [NP];
      bit s_f [NP];
      bit clr [NP];
      for (int r = 0; r < NP; r++) begin s_i[r] = 0; s_f[r] = 0; clr[r] = 0; end
      for (int i = 0; i < NA; i++)  if (a_v[i]) begin s_i[a_p[i]] = 1; s_f[a_p[i]] = 1; end
      for (int i = 0; i < NC; i++)  if (c_v[i]) begin s_i[c_p[i]] = 1; s_f[c_p[i]] = 1; end
      for (int i = 0; i < NL; i++)  if (l_v[i]) s_i[l_p[i]] = 1;
      for (int i = 0; i < NWK; i++) if (w_v[i]) clr[w_p[i]] = 1;
      for (int i = 0; i < NWB; i++) if (b_v[i]) clr[b_p[i]] = 1;
      for (int r = 0; r < NP; r++) begin
         if (s_i[r]) ref_int[r] = 1; else if (clr[r]) ref_int[r] = 0;
         if (s_f[r]) ref_fp[r]  = 1; else if (clr[r]) ref_fp[r]  = 0;
      end
      ref_int[0] = 0;
   endtask

   // Called just after a falling edge with inputs set: compare reads, advance model, cross a rising edge.
   task automatic step(string tag);
      #1;
      for (int k = 0; k < NR; k++) begin
         check(tag, "int", k, rdy_int[k], !ref_int[r_p[k]]);
         check(tag, "fp",  k, rdy_fp[k],  !ref_fp[r_p[k]]);
      end
      model_update();
      @(negedge clk);
      clear_inputs();
   endtask

   task automatic read4(int a, int b, int c, int d);
      r_p[0] = IW'(a); r_p[1] = IW'(b); r_p[2] = IW'(c); r_p[3] = IW'(d);
   endtask

   initial begin
      #3000000;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      clear_inputs();
      r_p = '0;
      for (int r = 0; r < NP; r++) begin ref_int[r] = 0; ref_fp[r] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: every register ready after reset; R9 all four read ports
      for (int g = 0; g < NP / 4; g++) begin
         read4(4*g, 4*g+1, 4*g+2, 4*g+3);
         step("R1");
      end

      // R2 allocate 5 and 9; R8 same-cycle read of 5 and 9 still ready
      a_v = 2'b11; a_p[0] = 4'd5; a_p[1] = 4'd9; read4(5, 9, 5, 9);
      step("R8");
      read4(5, 9, 1, 2);
      step("R2");

      // R5 wake-up and cancel on 5 together; R3 wake-up alone on 9
      w_v = 2'b11; w_p[0] = 4'd5; w_p[1] = 4'd9; c_v = 1'b1; c_p[0] = 4'd5;
      read4(5, 9, 5, 9);
      step("R5");
      read4(5, 9, 5, 9);
      step("R5");

      // R4 write-back clears 5; R5 write-back against cancel on 9
      a_v = 2'b01; a_p[0] = 4'd9;
      step("R2");
      b_v = 2'b11; b_p[0] = 4'd5; b_p[1] = 4'd9; c_v = 1'b1; c_p[0] = 4'd9;
      step("R4");
      read4(5, 9, 5, 9);
      step("R4");

      // R7 allocate against wake-up and write-back on 7
      a_v = 2'b01; a_p[0] = 4'd7; w_v = 2'b01; w_p[0] = 4'd7; b_v = 2'b01; b_p[0] = 4'd7;
      read4(7, 7, 6, 8);
      step("R7");
      read4(7, 6, 8, 7);
      step("R7");

      // R6 load cancel on 3: int busy, fp unaffected
      l_v = 1'b1; l_p[0] = 4'd3; read4(3, 3, 3, 3);
      step("R6");
      read4(3, 3, 3, 3);
      step("R6");

      // R10 allocate and cancel on register 0
      a_v = 2'b01; a_p[0] = 4'd0; c_v = 1'b1; c_p[0] = 4'd0; read4(0, 0, 0, 0);
      step("R10");
      read4(0, 0, 0, 0);
      step("R10");

      // R11 random traffic with frequent collisions, compared every cycle
      for (int n = 0; n < 400; n++) begin
         a_v = NA'($urandom_range(0, 3));
         w_v = NWK'($urandom_range(0, 3));
         b_v = NWB'($urandom_range(0, 3));
         c_v = NC'($urandom_range(0, 1));
         l_v = NL'($urandom_range(0, 1));
         for (int i = 0; i < NA; i++)  a_p[i] = IW'($urandom_range(0, NP-1));
         for (int i = 0; i < NWK; i++) w_p[i] = IW'($urandom_range(0, NP-1));
         for (int i = 0; i < NWB; i++) b_p[i] = IW'($urandom_range(0, NP-1));
         for (int i = 0; i < NC; i++)  c_p[i] = IW'($urandom_range(0, NP-1));
         for (int i = 0; i < NL; i++)  l_p[i] = IW'($urandom_range(0, NP-1));
         for (int k = 0; k < NR; k++)  r_p[k] = IW'($urandom_range(0, NP-1));
         step("R11");
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule